// File: doc/BRIEF.md
# DDR Burst Read/Write Timing Engine

This block is the controller-side timing engine for a multi-bank, low-latency DDR memory with an SRAM-style command interface. The host presents single-rate read or write commands with a bank and an address. The engine places each accepted command on the memory command outputs one cycle later. From the programmed read latency and burst length it then works out which clock cycles will carry that command's data. Every data cycle carries two beats, one on each clock edge, so a burst of BL beats fills BL/2 clock cycles.

Write latency is always the read latency plus one. During a write window the engine asserts the write-data output enable and passes the host's rising-edge and falling-edge beats and byte masks to the memory-side outputs. A set mask bit marks its byte lane as not to be written. During a read window the engine raises a data-valid strobe that frames the expected read capture cycles. It also drops on-die termination for exactly those cycles; termination stays on while the bus is idle and during writes. A delay-line schedule keeps one bit per future cycle for reads and one for writes. Any number of overlapping bursts can therefore be tracked, and a command whose data window would land on a cycle already claimed is refused.

A small state machine guards the mode registers. It has two states. ST_UNCONF is the state after reset, and all commands are refused there. ST_READY is entered through the transition "first legal mode set", taken from ST_UNCONF. In ST_READY each further legal mode set relatches latency and burst length while the engine stays in ST_READY.

Top module: `ddr_burst_timing_engine`

## Requirements
- R1: After reset the engine is in ST_UNCONF with mem_cmd_valid, cmd_err, dq_oe and rd_valid low and odt_en high. A command sampled before the first legal mode set is refused: cmd_err is high in the following cycle and nothing is issued.
- R2: A mode_set pulse is legal when mode_rl is in the range 3 to 15 and mode_bl is 0 (2 beats), 1 (4 beats) or 2 (8 beats). A legal pulse latches both values. A pulse with mode_bl = 3 or with mode_rl outside that range changes neither the state nor the latched values.
- R3: A command accepted at rising edge E appears on mem_cmd_valid, mem_cmd_write, mem_bank and mem_addr in the cycle right after E, for exactly one cycle.
- R4: A read accepted at edge E raises rd_valid for BL/2 consecutive cycles. The first of them is the cycle after edge E+RL.
- R5: A write accepted at edge E raises dq_oe for BL/2 consecutive cycles. The first of them is the cycle after edge E+RL+1. In those cycles dq_rise, dq_fall, dm_rise and dm_fall equal wr_data_rise, wr_data_fall, wr_mask_rise and wr_mask_fall. Outside those cycles all four are zero.
- R6: odt_en is low exactly in the cycles in which rd_valid is high, and high otherwise, including during write windows.
- R7: A command whose data window would share any cycle with a read or write window already scheduled is refused. cmd_err pulses in the next cycle, nothing is issued, and no window is added.
- R8: Latched latency and burst length apply only to commands sampled after the mode_set edge. A command sampled on the same edge as mode_set uses the old values, and bursts already scheduled keep their timing.
- R9: Reads issued BL/2 cycles apart produce back-to-back rd_valid windows with no gap, for example reads at T0 and T2 with a 4-beat burst.
- R10: rd_valid and dq_oe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_set | input | 1 | Pulse that latches mode_rl and mode_bl if legal |
| mode_rl | input | 4 | Requested read latency in cycles (3 to 15) |
| mode_bl | input | 2 | Burst code: 0 = 2 beats, 1 = 4, 2 = 8, 3 illegal |
| cmd_valid | input | 1 | Host command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 3 | Target bank |
| cmd_addr | input | 20 | Target address |
| wr_data_rise | input | 18 | Host write beat for the rising edge |
| wr_data_fall | input | 18 | Host write beat for the falling edge |
| wr_mask_rise | input | 2 | Byte masks for the rising beat (1 = do not write) |
| wr_mask_fall | input | 2 | Byte masks for the falling beat |
| mem_cmd_valid | output | 1 | Command issued to memory this cycle |
| mem_cmd_write | output | 1 | Issued command is a write |
| mem_bank | output | 3 | Issued bank |
| mem_addr | output | 20 | Issued address |
| cmd_err | output | 1 | Previous-cycle command was refused |
| dq_oe | output | 1 | Write data driven this cycle |
| dq_rise | output | 18 | Memory-side rising-edge write beat |
| dq_fall | output | 18 | Memory-side falling-edge write beat |
| dm_rise | output | 2 | Memory-side rising-edge byte masks |
| dm_fall | output | 2 | Memory-side falling-edge byte masks |
| rd_valid | output | 1 | Read data expected this cycle (data-valid strobe) |
| odt_en | output | 1 | On-die termination enable |

## Verification
Command issue and cmd_err are due in the cycle right after the sampling edge. The read strobe and termination drop are due RL cycles after the command edge, and write enable with its pass-through beats RL+1 cycles after it, each lasting BL/2 cycles. The reference model records, for each command edge, the absolute cycle numbers its windows must occupy, using the latency and burst length it held at that edge. Every output is then compared half a cycle after each rising edge against the entry for that edge. This covers refused commands, mode changes while bursts are in flight, and read/write pairs one cycle apart.

// File: rtl/ddr_te_pkg.sv
package ddr_te_pkg;

    typedef enum logic {
        ST_UNCONF = 1'b0,
        ST_READY  = 1'b1
    } te_state_e;

    // burst code -> clock cycles on the bus (two beats per cycle)
    function automatic logic [2:0] burst_cycles(input logic [1:0] code);
        logic [2:0] r;
        unique case (code)
            2'd0:    r = 3'd1;
            2'd1:    r = 3'd2;
            default: r = 3'd4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ddr_te_mode.sv
module ddr_te_mode
    import ddr_te_pkg::*;
#(
    parameter int MIN_RL = 3,
    parameter int MAX_RL = 15,
    localparam int RL_W  = $clog2(MAX_RL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_set,
    input  logic [RL_W-1:0] mode_rl,
    input  logic [1:0]      mode_bl,
    output logic            ready,
    output logic [RL_W-1:0] rl_q,
    output logic [2:0]      bcyc_q
);

    te_state_e state_q, state_d;
    logic      legal;

    assign legal = mode_set && (mode_bl != 2'd3) &&
                   (int'(mode_rl) >= MIN_RL) && (int'(mode_rl) <= MAX_RL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCONF: if (legal) state_d = ST_READY;
            ST_READY:  state_d = ST_READY;
            default:   state_d = ST_UNCONF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNCONF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rl_q   <= RL_W'(MIN_RL);
            bcyc_q <= 3'd1;
        end else if (legal) begin
            rl_q   <= mode_rl;
            bcyc_q <= burst_cycles(mode_bl);
        end
    end

    assign ready = (state_q == ST_READY);

    p_rl_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (int'(rl_q) >= MIN_RL && int'(rl_q) <= MAX_RL));
    p_bl_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ($countones(bcyc_q) == 1));

endmodule

// File: rtl/ddr_te_sched.sv
module ddr_te_sched #(
    parameter int DEPTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DEPTH-1:0] load_mask,
    output logic [DEPTH-1:0] ahead,
    output logic             now
);

    // bit j: bus occupied in the cycle j edges from now
    logic [DEPTH-1:0] slots_q;

    assign ahead = {1'b0, slots_q[DEPTH-1:1]};
    assign now   = slots_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n)    slots_q <= '0;
        else if (load) slots_q <= ahead | load_mask;
        else           slots_q <= ahead;
    end

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ((load_mask & ahead) == '0));

endmodule

// File: rtl/ddr_burst_timing_engine.sv
module ddr_burst_timing_engine
    import ddr_te_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 20,
    parameter int DQ_W   = 18,
    parameter int DM_W   = 2,
    parameter int MIN_RL = 3,
    parameter int MAX_RL = 15,
    localparam int RL_W  = $clog2(MAX_RL + 1),
    localparam int DEPTH = MAX_RL + 1 + 4,
    localparam int SW    = $clog2(DEPTH + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_set,
    input  logic [RL_W-1:0]   mode_rl,
    input  logic [1:0]        mode_bl,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DQ_W-1:0]   wr_data_rise,
    input  logic [DQ_W-1:0]   wr_data_fall,
    input  logic [DM_W-1:0]   wr_mask_rise,
    input  logic [DM_W-1:0]   wr_mask_fall,
    output logic              mem_cmd_valid,
    output logic              mem_cmd_write,
    output logic [BANK_W-1:0] mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cmd_err,
    output logic              dq_oe,
    output logic [DQ_W-1:0]   dq_rise,
    output logic [DQ_W-1:0]   dq_fall,
    output logic [DM_W-1:0]   dm_rise,
    output logic [DM_W-1:0]   dm_fall,
    output logic              rd_valid,
    output logic              odt_en
);

    logic             ready;
    logic [RL_W-1:0]  rl_q;
    logic [2:0]       bcyc_q;
    logic [SW-1:0]    win_start, win_stop;
    logic [DEPTH-1:0] win, rd_ahead, wr_ahead;
    logic             rd_now, wr_now, clash, accept;

    ddr_te_mode #(.MIN_RL(MIN_RL), .MAX_RL(MAX_RL)) u_mode (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_rl(mode_rl),
        .mode_bl(mode_bl), .ready(ready), .rl_q(rl_q), .bcyc_q(bcyc_q)
    );

    // data window of the candidate command, in cycles after this edge
    assign win_start = cmd_write ? SW'(rl_q) + SW'(1) : SW'(rl_q);
    assign win_stop  = win_start + SW'(bcyc_q);

    for (genvar j = 0; j < DEPTH; j++) begin : g_win
        assign win[j] = (SW'(j) >= win_start) && (SW'(j) < win_stop);
    end

    assign clash  = |(win & (rd_ahead | wr_ahead));
    assign accept = cmd_valid && ready && !clash;

    ddr_te_sched #(.DEPTH(DEPTH)) u_rd_sched (
        .clk(clk), .rst_n(rst_n), .load(accept && !cmd_write),
        .load_mask(win), .ahead(rd_ahead), .now(rd_now)
    );

    ddr_te_sched #(.DEPTH(DEPTH)) u_wr_sched (
        .clk(clk), .rst_n(rst_n), .load(accept && cmd_write),
        .load_mask(win), .ahead(wr_ahead), .now(wr_now)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cmd_valid <= 1'b0;
            mem_cmd_write <= 1'b0;
            mem_bank      <= '0;
            mem_addr      <= '0;
            cmd_err       <= 1'b0;
        end else begin
            mem_cmd_valid <= accept;
            cmd_err       <= cmd_valid && !accept;
            if (accept) begin
                mem_cmd_write <= cmd_write;
                mem_bank      <= cmd_bank;
                mem_addr      <= cmd_addr;
            end
        end
    end

    always_comb begin
        dq_oe    = wr_now;
        dq_rise  = wr_now ? wr_data_rise : '0;
        dq_fall  = wr_now ? wr_data_fall : '0;
        dm_rise  = wr_now ? wr_mask_rise : '0;
        dm_fall  = wr_now ? wr_mask_fall : '0;
        rd_valid = rd_now;
        odt_en   = !rd_now;
    end

    p_bus_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && dq_oe));
    p_err_no_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !mem_cmd_valid);
    p_issue_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> $past(ready));
    p_odt_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> odt_en);

endmodule

// File: tb/ddr_burst_timing_engine_bench.sv
module ddr_burst_timing_engine_bench;

    localparam int DQ_W = 18;
    localparam int DM_W = 2;
    localparam int NCYC = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_set = 1'b0;
    logic [3:0]  mode_rl = '0;
    logic [1:0]  mode_bl = '0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [2:0]  cmd_bank = '0;
    logic [19:0] cmd_addr = '0;
    logic [DQ_W-1:0] wdr = '0, wdf = '0;
    logic [DM_W-1:0] wmr = '0, wmf = '0;
    logic        mem_cmd_valid, mem_cmd_write, cmd_err, dq_oe, rd_valid, odt_en;
    logic [2:0]  mem_bank;
    logic [19:0] mem_addr;
    logic [DQ_W-1:0] dq_rise, dq_fall;
    logic [DM_W-1:0] dm_rise, dm_fall;

    always #2 clk = ~clk;

    ddr_burst_timing_engine u_ddr_burst_timing_engine (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_rl(mode_rl),
        .mode_bl(mode_bl), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .wr_data_rise(wdr),
        .wr_data_fall(wdf), .wr_mask_rise(wmr), .wr_mask_fall(wmf),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
        .mem_bank(mem_bank), .mem_addr(mem_addr), .cmd_err(cmd_err),
        .dq_oe(dq_oe), .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dm_rise(dm_rise), .dm_fall(dm_fall), .rd_valid(rd_valid), .odt_en(odt_en)
    );

    int vectors = 0, miscompares = 0, cyc = 0;
    bit exp_rd [NCYC];
    bit exp_wr [NCYC];
    bit m_ready = 0;
    int m_rl = 3, m_bl = 2;
    bit e_cv, e_cw, e_err;
    int e_bank, e_addr;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    // behavioural reference: absolute-cycle occupancy tables
    task automatic model(input int e, input bit cv, wr, input int bank, addr,
                         input bit ms, input int rl, bl);
        e_cv = 0; e_err = 0;
        if (cv) begin
            if (!m_ready) e_err = 1;
            else begin
                int s = e + m_rl + (wr ? 1 : 0);
                bit coll = 0;
                for (int k = s; k < s + m_bl / 2; k++)
                    if (exp_rd[k] || exp_wr[k]) coll = 1;
                if (coll) e_err = 1;
                else begin
                    for (int k = s; k < s + m_bl / 2; k++)
                        if (wr) exp_wr[k] = 1; else exp_rd[k] = 1;
                    e_cv = 1; e_cw = wr; e_bank = bank; e_addr = addr;
                end
            end
        end
        if (ms && rl >= 3 && rl <= 15 && bl != 3) begin
            m_rl = rl; m_bl = 2 << bl; m_ready = 1;
        end
    endtask

    task automatic step(input bit cv, wr, input int bank, addr,
                        input bit ms, input int rl, bl, input string tag);
        cmd_valid = cv; cmd_write = wr; cmd_bank = 3'(bank); cmd_addr = 20'(addr);
        mode_set = ms; mode_rl = 4'(rl); mode_bl = 2'(bl);
        wdr = DQ_W'(cyc * 37 + 5); wdf = DQ_W'(cyc * 91 + 3);
        wmr = DM_W'(cyc); wmf = DM_W'(cyc + 1);
        @(posedge clk);
        model(cyc, cv, wr, bank, addr, ms, rl, bl);
        @(negedge clk);
        chk({tag, "/R3"}, "mem_cmd_valid", mem_cmd_valid, e_cv);
        if (e_cv) begin
            chk({tag, "/R3"}, "mem_cmd_write", mem_cmd_write, e_cw);
            chk({tag, "/R3"}, "mem_bank", mem_bank, e_bank);
            chk({tag, "/R3"}, "mem_addr", mem_addr, e_addr);
        end
        chk({tag, "/R7"}, "cmd_err", cmd_err, e_err);
        chk({tag, "/R4"}, "rd_valid", rd_valid, exp_rd[cyc]);
        chk({tag, "/R6"}, "odt_en", odt_en, !exp_rd[cyc]);
        chk({tag, "/R5"}, "dq_oe", dq_oe, exp_wr[cyc]);
        chk({tag, "/R5"}, "dq_rise", dq_rise, exp_wr[cyc] ? wdr : 0);
        chk({tag, "/R5"}, "dq_fall", dq_fall, exp_wr[cyc] ? wdf : 0);
        chk({tag, "/R5"}, "dm_rise", dm_rise, exp_wr[cyc] ? wmr : 0);
        chk({tag, "/R5"}, "dm_fall", dm_fall, exp_wr[cyc] ? wmf : 0);
        chk({tag, "/R10"}, "bus_excl", (rd_valid && dq_oe) ? 1 : 0, 0);
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "mem_cmd_valid", mem_cmd_valid, 0);
        chk("R1", "cmd_err", cmd_err, 0);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "dq_oe", dq_oe, 0);
        chk("R1", "odt_en", odt_en, 1);
        rst_n = 1'b1;
        // R1: refused while unconfigured
        step(1, 0, 1, 100, 0, 0, 0, "R1");
        idle(2, "R1");
        // R2: illegal mode sets ignored
        step(0, 0, 0, 0, 1, 4, 3, "R2");
        step(1, 0, 2, 5, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 1, 2, 1, "R2");
        step(1, 1, 2, 6, 0, 0, 0, "R2");
        idle(2, "R2");
        // R2: legal RL 4, BL 4
        step(0, 0, 0, 0, 1, 4, 1, "R2");
        step(1, 0, 3, 1234, 0, 0, 0, "R4");
        idle(8, "R4");
        step(1, 1, 4, 777, 0, 0, 0, "R5");
        idle(9, "R5");
        // R9: reads two cycles apart, different banks
        step(1, 0, 0, 10, 0, 0, 0, "R9");
        idle(1, "R9");
        step(1, 0, 2, 11, 0, 0, 0, "R9");
        idle(1, "R9");
        step(1, 0, 4, 12, 0, 0, 0, "R9");
        idle(8, "R9");
        // R7: collisions
        step(1, 0, 1, 20, 0, 0, 0, "R7");
        step(1, 0, 2, 21, 0, 0, 0, "R7");
        idle(8, "R7");
        step(1, 1, 1, 22, 0, 0, 0, "R7");
        step(1, 0, 2, 23, 0, 0, 0, "R7");
        idle(8, "R7");
        step(1, 0, 1, 24, 0, 0, 0, "R10");
        step(1, 1, 2, 25, 0, 0, 0, "R10");
        idle(9, "R10");
        // BL2, RL3: a read every cycle
        step(0, 0, 0, 0, 1, 3, 0, "R2");
        for (int i = 0; i < 5; i++) step(1, 0, i, 40 + i, 0, 0, 0, "R9");
        idle(6, "R9");
        // R8: in-flight burst keeps timing; same-edge command uses old mode
        step(0, 0, 0, 0, 1, 9, 2, "R8");
        step(1, 0, 5, 50, 1, 3, 1, "R8");
        step(1, 1, 6, 51, 0, 0, 0, "R8");
        idle(16, "R8");
        // BL8 at max latency, write then read
        step(0, 0, 0, 0, 1, 15, 2, "R5");
        step(1, 1, 7, 60, 0, 0, 0, "R5");
        step(1, 0, 7, 61, 0, 0, 0, "R7");
        idle(3, "R7");
        step(1, 0, 7, 62, 0, 0, 0, "R4");
        idle(26, "R4");
        finish_run();
    end

endmodule